// File: doc/BRIEF.md
# Dual-Space Internal Data Memory Steering

This block sits between an 8-bit core's operand path and its internal data storage. That storage has two parts. The first is a 256-byte RAM. The second is a separate special-function register space, which lives in external logic. The RAM's upper half and the register space use the same addresses, 80H through FFH. Because of this, the address alone cannot tell which store an access means. The block settles it with an addressing-mode flag that comes with each access.

Addresses below 80H always go to the lower RAM. An access above 7FH goes one of two ways:

- In direct mode it is sent out on a simple register-space port. The external logic answers a read in the same cycle on its read-data input.
- In indirect mode, which stack pushes and pops also use, it goes to the upper RAM bytes instead.

Writes complete at the clock edge that samples them. Read data from either store appears, registered, on the cycle after the read strobe. Reset clears only the read-data register. RAM contents survive reset, while the external logic reinitialises its own registers.

Top module: `dmem_steer`

## Requirements
- R1: An access with address bit 7 clear (00H-7FH) reaches RAM in both addressing modes, and the register-space select output stays low.
- R2: A direct-mode access (indirect = 0) with address bit 7 set drives the register-space select high, presents the full 8-bit address on the port, and leaves RAM unchanged.
- R3: An indirect-mode access (indirect = 1) with address bit 7 set reaches the upper RAM byte at that address and does not touch the register space. An indirect write to A0H leaves a direct read of A0H returning the register value.
- R4: A write completes in one clock: a read of the same location, issued on the next access, returns the written byte.
- R5: Read data appears on rdData in the cycle after the read strobe and holds unchanged in any cycle after which no read was strobed.
- R6: A read routed to the register space returns the value present on sfrRdata in the strobe cycle.
- R7: Reset forces rdData to 00H and leaves every RAM byte unchanged.
- R8: With neither strobe asserted, the register-space select is low.
- R9: The register-space write flag is high for a routed write and low for a routed read, and the write byte is forwarded on sfrWdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Access address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| indirect | input | 1 | 1 = indirect (and stack) addressing, 0 = direct |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte, valid the cycle after rdEn |
| sfrSel | output | 1 | High when the current access is routed to the register space |
| sfrWrite | output | 1 | High for a routed write, low for a routed read |
| sfrAddr | output | 8 | Register-space address |
| sfrWdata | output | 8 | Register-space write byte |
| sfrRdata | input | 8 | Register-space read byte, answered in the strobe cycle |

## Verification
The properties take for granted that rdEn and wrEn are never high together. They also assume the register space answers a read combinationally within the strobe cycle. The stimulus follows both rules. Every access is a single read or a single write, separated by idle cycles. The bench stands in for the external register space with a model that answers reads from the address at once and clears itself on reset. Every address is swept in both modes, so the steering is exercised on each byte without depending on undefined register locations.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // Strobes sent from the decode control to the storage datapath
  typedef struct packed {
    logic ramWr;
    logic ramRd;
    logic sfrWr;
    logic sfrRd;
  } strobe_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              indirect,
  output strobe_t           strobe
);

  localparam int TOP_BIT = ADDR_W - 1;

  logic upperHalf;
  logic toRegSpace;

  always_comb begin
    upperHalf    = addr[TOP_BIT];
    // Upper half is shared: the mode, not the address, picks the store
    toRegSpace   = upperHalf && !indirect;
    strobe.ramWr = wrEn && !toRegSpace;
    strobe.ramRd = rdEn && !toRegSpace;
    strobe.sfrWr = wrEn && toRegSpace;
    strobe.sfrRd = rdEn && toRegSpace;
  end

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              sfrSel,
  output logic              sfrWrite
);

  localparam int DEPTH = 1 << ADDR_W;

  // One array covers lower and upper RAM; the address bits map directly
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] rdReg;

  // No reset on the array: contents survive reset
  always_ff @(posedge clk) begin
    if (strobe.ramWr) ram[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strobe.sfrRd) begin
      rdReg <= sfrRdata;
    end else if (strobe.ramRd) begin
      rdReg <= ram[addr];
    end
  end

  assign rdData   = rdReg;
  assign sfrSel   = strobe.sfrRd | strobe.sfrWr;
  assign sfrWrite = strobe.sfrWr;

endmodule

// File: rtl/dmem_steer.sv
module dmem_steer
  import steer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              indirect,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sfrSel,
  output logic              sfrWrite,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] sfrRdata
);

  strobe_t strobe;

  steer_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr     (addr),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .indirect (indirect),
    .strobe   (strobe)
  );

  steer_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (wrData),
    .sfrRdata (sfrRdata),
    .rdData   (rdData),
    .sfrSel   (sfrSel),
    .sfrWrite (sfrWrite)
  );

  assign sfrAddr  = addr;
  assign sfrWdata = wrData;

endmodule

// File: rtl/dmem_steer_chk.sv
module dmem_steer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic              indirect,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              sfrSel,
  input logic              sfrWrite,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic [DATA_W-1:0] sfrWdata,
  input logic [DATA_W-1:0] sfrRdata
);

  AST_LOW_STAYS_RAM: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && !addr[ADDR_W-1]) |-> !sfrSel); // R1

  AST_DIRECT_UPPER_PORT: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && addr[ADDR_W-1] && !indirect) |-> (sfrSel && sfrAddr == addr)); // R2

  AST_INDIRECT_UPPER_RAM: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && addr[ADDR_W-1] && indirect) |-> !sfrSel); // R3

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R5

  AST_PORT_READ_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && sfrSel) |=> (rdData == $past(sfrRdata))); // R6

  AST_RESET_CLEARS_READ: assert property (@(posedge clk)
    !rstN |=> (rdData == '0)); // R7

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !wrEn) |-> !sfrSel); // R8

  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (sfrSel && !wrEn) |-> !sfrWrite); // R9

  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (sfrSel && wrEn) |-> (sfrWrite && sfrWdata == wrData)); // R9

endmodule

bind dmem_steer dmem_steer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_dmem_steer.sv
module tb_dmem_steer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic       indirect = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       sfrSel;
  logic       sfrWrite;
  logic [7:0] sfrAddr;
  logic [7:0] sfrWdata;
  logic [7:0] sfrRdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_steer dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .indirect(indirect), .wrData(wrData), .rdData(rdData),
    .sfrSel(sfrSel), .sfrWrite(sfrWrite), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata)
  );

  // Stand-in for the external register space; reinitialised by reset
  logic [7:0] regModel [128];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) regModel[i] <= 8'h00;
    end else if (sfrSel && sfrWrite) begin
      regModel[sfrAddr[6:0]] <= sfrWdata;
    end
  end
  assign sfrRdata = regModel[sfrAddr[6:0]];

  function automatic logic [7:0] lowVal(int a);
    return 8'((a * 5 + 17) & 255);
  endfunction
  function automatic logic [7:0] upVal(int a);
    return 8'(a * 3) ^ 8'hC3;
  endfunction
  function automatic logic [7:0] regVal(int a);
    return 8'((a * 11 + 1) & 255) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input bit ind, input logic [7:0] d,
                         input logic expSel, input string req);
    @(negedge clk);
    addr = 8'(a); indirect = ind; wrData = d; wrEn = 1'b1;
    #1;
    check(req, {7'd0, sfrSel}, {7'd0, expSel});
    if (expSel) check("R9", {7'd0, sfrWrite}, 8'd1);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input int a, input bit ind, input logic expSel,
                        input string req, output logic [7:0] got);
    @(negedge clk);
    addr = 8'(a); indirect = ind; rdEn = 1'b1;
    #1;
    check(req, {7'd0, sfrSel}, {7'd0, expSel});
    if (expSel) check("R9", {7'd0, sfrWrite}, 8'd0);
    @(negedge clk);
    rdEn = 1'b0;
    got = rdData;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R7", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    // R8: idle select low
    check("R8", {7'd0, sfrSel}, 8'd0);

    // R1: fill lower RAM, alternating modes
    for (int a = 0; a < 128; a++) doWrite(a, a[0], lowVal(a), 1'b0, "R1");
    // R3: upper RAM through indirect mode
    for (int a = 128; a < 256; a++) doWrite(a, 1'b1, upVal(a), 1'b0, "R3");
    // R2: register space through direct mode
    for (int a = 128; a < 256; a++) doWrite(a, 1'b0, regVal(a), 1'b1, "R2");

    // R1: lower RAM visible in both modes
    for (int a = 0; a < 128; a++) begin
      for (int m = 0; m < 2; m++) begin
        doRead(a, m[0], 1'b0, "R1", got);
        check("R1", got, lowVal(a));
      end
    end
    // R3: indirect upper reads give RAM, untouched by the direct writes (R2)
    for (int a = 128; a < 256; a++) begin
      doRead(a, 1'b1, 1'b0, "R3", got);
      check("R3", got, upVal(a));
    end
    // R6: direct upper reads give the register value
    for (int a = 128; a < 256; a++) begin
      doRead(a, 1'b0, 1'b1, "R6", got);
      check("R6", got, regVal(a));
    end

    // R3: indirect write at A0H leaves the register at A0H alone
    doWrite(8'hA0, 1'b1, 8'h3C, 1'b0, "R3");
    doRead(8'hA0, 1'b0, 1'b1, "R3", got);
    check("R3", got, regVal(8'hA0));
    // R4: write then immediate read back
    doRead(8'hA0, 1'b1, 1'b0, "R4", got);
    check("R4", got, 8'h3C);
    doWrite(8'h15, 1'b0, 8'hE7, 1'b0, "R4");
    doRead(8'h15, 1'b1, 1'b0, "R4", got);
    check("R4", got, 8'hE7);

    // R5: rdData holds through idle cycles and writes
    held = rdData;
    repeat (3) @(negedge clk);
    check("R5", rdData, held);
    doWrite(8'h20, 1'b1, 8'h99, 1'b0, "R5");
    check("R5", rdData, held);
    doWrite(8'hC0, 1'b0, 8'h42, 1'b1, "R5");
    check("R5", rdData, held);

    // R7: reset clears rdData, RAM survives, register space reinitialised
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7", rdData, 8'h00);
    rstN = 1'b1;
    doRead(8'h15, 1'b0, 1'b0, "R7", got);
    check("R7", got, 8'hE7);
    doRead(8'hA0, 1'b1, 1'b0, "R7", got);
    check("R7", got, 8'h3C);
    for (int a = 129; a < 256; a += 17) begin
      doRead(a, 1'b1, 1'b0, "R7", got);
      check("R7", got, upVal(a));
    end
    doRead(8'hC0, 1'b0, 1'b1, "R6", got);
    check("R6", got, 8'h00);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule